// File: doc/BRIEF.md
# TDM Audio Serial Receiver

This block is the slave-side deserializer of a time-division multiplexed audio link that feeds six playback channels. The bit clock and the frame sync both come from outside; the block runs directly on the bit clock, samples the frame sync and the serial data line on its rising edge, and locks its bit position to the frame sync's low-to-high transition. A frame is 256 bit clocks long and carries eight 32-bit slots. The first six slots hold the channel samples and the last two are dropped.

Each sample sits left-justified in its slot, most significant bit first. The word length is selected by a 2-bit input among 16, 18, 20 and 24 bits. The slot bits beyond that length are not used. All six samples are put out together as 24-bit left-aligned words, with the unused low bits at zero, and a one-clock strobe marks each update. A frame sync transition that comes at any point other than the expected frame boundary raises a sticky error flag, and the bit count restarts from that transition.

Top module: `tdm_rx_slave`

## Requirements
- R1: While reset is held and right after it is released, `ch_valid` is 0, `sync_err` is 0 and `ch_data` is all zero.
- R2: The rising clock edge that first samples `fsync` high after it was low is the sync edge. The next rising edge samples `sdata` as the most significant bit of slot 0.
- R3: Bits arrive MSB first. Slot n occupies the 32 bit times that begin 32·n bit times after the MSB of slot 0. Channel k (k = 0..5) is taken from slot k and appears on `ch_data[24k+23:24k]`.
- R4: `word_len` selects the sample length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Slot bits after that length are ignored. Each channel is output left-aligned in 24 bits, with the low (24 − length) bits at zero.
- R5: `ch_valid` is high for exactly one clock per frame, in the clock that follows the edge sampling the last bit of slot 5 (bit 191 counted from the MSB of slot 0). All six channels change together in that clock and hold their value at every other time.
- R6: The content of slots 6 and 7 neither changes `ch_data` nor produces a `ch_valid` pulse.
- R7: A sync edge that comes exactly 256 clocks after the previous one leaves `sync_err` at 0. A sync edge at any other distance sets `sync_err`, which then stays at 1 until reset, and slot capture restarts from that edge. The first sync edge after reset never sets `sync_err`.
- R8: Only the low-to-high transition of `fsync` counts. Keeping `fsync` high for several clocks creates no further sync edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, 256 times the frame rate; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fsync | input | 1 | Frame sync from the external source; its rise marks a frame start |
| sdata | input | 1 | Serial TDM data line |
| word_len | input | 2 | Sample length code: 0=16, 1=18, 2=20, 3=24 bits |
| ch_data | output | 144 | Six 24-bit left-aligned samples, channel k at bits 24k+23:24k |
| ch_valid | output | 1 | One-clock strobe when all six channels have been updated |
| sync_err | output | 1 | Sticky flag: a frame sync rise came off the 256-clock boundary |

## Verification
The assertions assume that `word_len` stays constant from the MSB of slot 0 to the end of slot 5 in every frame. The stimulus changes it only after a frame's strobe has been checked, while slots 6 and 7 are being sent. They also assume that `fsync` is a clean level sampled on the rising edge. The bench drives both `fsync` and `sdata` on the falling edge, so that every bit is stable for half a period on either side of the capturing edge. Lock is taken from the first sync edge, so the stimulus always gives one sync edge before it starts checking sample content. The idle gap before the misaligned sync edge is kept shorter than the 192 clocks that would produce a strobe while the counter runs freely.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic [1:0] {
    WLEN_16 = 2'd0,
    WLEN_18 = 2'd1,
    WLEN_20 = 2'd2,
    WLEN_24 = 2'd3
  } wlen_e;

  // Number of valid sample bits for a word-length code.
  function automatic int wlen_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WLEN_16: return 16;
      WLEN_18: return 18;
      WLEN_20: return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/tdm_rx_frame_track.sv
module tdm_rx_frame_track #(
  parameter int FRAME_LEN = 256,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             bit_en,
  output logic             sync_err
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  logic             fs_q, fs_n;
  logic             locked_q, locked_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             err_q, err_n;
  logic             fs_rise;

  // Next-state logic
  always_comb begin
    fs_rise  = fsync & ~fs_q;
    fs_n     = fsync;
    locked_n = locked_q | fs_rise;
    cnt_n    = cnt_q;
    err_n    = err_q;
    if (fs_rise) begin
      cnt_n = '0;
      if (locked_q && (cnt_q != LAST_BIT)) err_n = 1'b1;
    end else if (locked_q) begin
      cnt_n = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      fs_q     <= fs_n;
      locked_q <= locked_n;
      cnt_q    <= cnt_n;
      err_q    <= err_n;
    end
  end

  assign bit_cnt  = cnt_q;
  assign bit_en   = locked_q & ~fs_rise;
  assign sync_err = err_q;

  // R7: once raised, the sync error flag never clears without reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: a rise exactly on the frame boundary leaves a clean flag clean
  assert_aligned_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !fs_q && locked_q && cnt_q == LAST_BIT && !err_q) |=> !err_q);

  // R7: the first sync rise after reset is never an error
  assert_first_sync_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> !err_q);

  // R8: fsync held high is not a new rise, counting carries on
  assert_level_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && fsync && locked_q && cnt_q != LAST_BIT) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/tdm_rx_slot_shift.sv
module tdm_rx_slot_shift
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic [POS_W-1:0]    pos,
  input  logic                sdata,
  input  logic [1:0]          word_len,
  output logic [SAMPLE_W-1:0] acc
);

  logic [SAMPLE_W-1:0] acc_q, acc_n;
  int                  len;

  // Next-state: place each in-length bit at its left-aligned position
  always_comb begin
    len   = wlen_bits(word_len);
    acc_n = acc_q;
    if (bit_en) begin
      if (pos == '0) acc_n = '0;
      for (int j = 0; j < SAMPLE_W; j++) begin
        if ((int'(pos) == j) && (j < len)) acc_n[SAMPLE_W-1-j] = sdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign acc = acc_q;

  // R2/R3: the first bit of a slot lands in the sample MSB
  assert_msb_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos == '0) |=> acc_q[SAMPLE_W-1] == $past(sdata));

  // R4: bit times past the word length leave the assembled word untouched
  assert_tail_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos != '0 && int'(pos) >= wlen_bits(word_len)) |=> $stable(acc_q));

endmodule

// File: rtl/tdm_rx_sample_bank.sv
module tdm_rx_sample_bank
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int ACTIVE_CH = 6,
  parameter int SLOT_W    = 32,
  parameter int SLOT_IDXW = 3,
  localparam int POS_W    = $clog2(SLOT_W),
  localparam int STAGE_N  = ACTIVE_CH - 1,
  localparam int OUT_W    = SAMPLE_W * ACTIVE_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic [SLOT_IDXW-1:0] slot,
  input  logic [POS_W-1:0]     pos,
  input  logic [SAMPLE_W-1:0]  acc,
  input  logic [1:0]           word_len,
  output logic [OUT_W-1:0]     ch_data,
  output logic                 ch_valid
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_W - 1);

  logic [SAMPLE_W-1:0] stage_q [STAGE_N];
  logic [SAMPLE_W-1:0] stage_n [STAGE_N];
  logic [OUT_W-1:0]    out_q, out_n;
  logic                valid_q, valid_n;
  logic                slot_end;

  // Next-state logic
  always_comb begin
    slot_end = bit_en && (pos == LAST_POS);
    out_n    = out_q;
    valid_n  = 1'b0;
    for (int k = 0; k < STAGE_N; k++) begin
      stage_n[k] = stage_q[k];
      if (slot_end && int'(slot) == k) stage_n[k] = acc;
    end
    if (slot_end && int'(slot) == ACTIVE_CH - 1) begin
      for (int k = 0; k < STAGE_N; k++) out_n[k*SAMPLE_W +: SAMPLE_W] = stage_q[k];
      out_n[STAGE_N*SAMPLE_W +: SAMPLE_W] = acc;
      valid_n = 1'b1;
    end
  end

  // Staging registers, one per early channel
  for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_n[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      out_q   <= out_n;
      valid_q <= valid_n;
    end
  end

  assign ch_data  = out_q;
  assign ch_valid = valid_q;

  // Check helper: low bits of each presented sample below the word length
  logic tail_zero;
  always_comb begin
    tail_zero = 1'b1;
    for (int k = 0; k < ACTIVE_CH; k++) begin
      for (int b = 0; b < SAMPLE_W; b++) begin
        if ((b < SAMPLE_W - wlen_bits(word_len)) && out_q[k*SAMPLE_W + b]) tail_zero = 1'b0;
      end
    end
  end

  // R5: strobe lasts a single clock
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |=> !ch_valid);

  // R5: samples move only together with the strobe
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_valid |-> $stable(ch_data));

  // R4: presented samples carry zeros below the selected length
  assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> tail_zero);

  // R6: bits of the discarded slots never raise the strobe
  assert_unused_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && int'(slot) >= ACTIVE_CH) |=> !ch_valid);

endmodule

// File: rtl/tdm_rx_slave.sv
module tdm_rx_slave #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int SLOTS     = 8,
  parameter int ACTIVE_CH = 6,
  localparam int FRAME_LEN = SLOT_W * SLOTS,
  localparam int CNT_W     = $clog2(FRAME_LEN),
  localparam int POS_W     = $clog2(SLOT_W),
  localparam int SLOT_IDXW = CNT_W - POS_W,
  localparam int OUT_W     = SAMPLE_W * ACTIVE_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             sdata,
  input  logic [1:0]       word_len,
  output logic [OUT_W-1:0] ch_data,
  output logic             ch_valid,
  output logic             sync_err
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0]    bit_cnt;
  logic                bit_en;
  logic [SAMPLE_W-1:0] acc;

  tdm_rx_frame_track #(.FRAME_LEN(FRAME_LEN)) u_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fsync    (fsync),
    .bit_cnt  (bit_cnt),
    .bit_en   (bit_en),
    .sync_err (sync_err)
  );

  tdm_rx_slot_shift #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .pos      (bit_cnt[POS_W-1:0]),
    .sdata    (sdata),
    .word_len (word_len),
    .acc      (acc)
  );

  tdm_rx_sample_bank #(
    .SAMPLE_W  (SAMPLE_W),
    .ACTIVE_CH (ACTIVE_CH),
    .SLOT_W    (SLOT_W),
    .SLOT_IDXW (SLOT_IDXW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .slot     (bit_cnt[CNT_W-1:POS_W]),
    .pos      (bit_cnt[POS_W-1:0]),
    .acc      (acc),
    .word_len (word_len),
    .ch_data  (ch_data),
    .ch_valid (ch_valid)
  );

  // R1: outputs are quiet while the internal reset is held
  always_comb begin
    if (!rst_int_n) begin
      assert_reset_quiet_R1: assert (!ch_valid && !sync_err);
    end
  end

endmodule

// File: tb/sim_tdm_rx_slave.sv
module sim_tdm_rx_slave;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fsync = 1'b0;
  logic         sdata = 1'b0;
  logic [1:0]   word_len = 2'd3;
  logic [143:0] ch_data;
  logic         ch_valid;
  logic         sync_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] slot_w [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_rx_slave u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .word_len(word_len), .ch_data(ch_data), .ch_valid(ch_valid), .sync_err(sync_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] expect_ch(input logic [31:0] w, input logic [1:0] code);
    int n;
    logic [SW-1:0] v;
    n = (code == 2'd0) ? 16 : (code == 2'd1) ? 18 : (code == 2'd2) ? 20 : 24;
    v = w[31:8];
    for (int b = 0; b < SW; b++) if (b < SW - n) v[b] = 1'b0;
    return v;
  endfunction

  // Drives one 256-bit frame; the sync edge was set up by the caller or the
  // previous frame. hold = clocks fsync stays high; next_sync starts a new frame.
  task automatic run_frame(input int hold, input bit next_sync, input string tag);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == 191) check(ch_valid == 1'b0, "R5", {tag, " valid early"}, 64'(ch_valid), 64'd0);
      if (i == 192) begin
        check(ch_valid == 1'b1, "R5", {tag, " valid strobe"}, 64'(ch_valid), 64'd1);
        for (int k = 0; k < 6; k++) begin
          check(ch_data[k*SW +: SW] == expect_ch(slot_w[k], word_len), "R3/R4",
                $sformatf("%s ch%0d", tag, k), 64'(ch_data[k*SW +: SW]),
                64'(expect_ch(slot_w[k], word_len)));
        end
      end
      if (i == 193) check(ch_valid == 1'b0, "R5", {tag, " valid one cycle"}, 64'(ch_valid), 64'd0);
      if (i == 255) begin
        // R6: slots 6 and 7 have been sent; channel 5 still shows slot 5
        check(ch_data[5*SW +: SW] == expect_ch(slot_w[5], word_len), "R6",
              {tag, " slots 6/7 ignored"}, 64'(ch_data[5*SW +: SW]),
              64'(expect_ch(slot_w[5], word_len)));
      end
      fsync = (i < hold - 1) || (i == 255 && next_sync);
      sdata = slot_w[i / 32][31 - (i % 32)];
    end
  endtask

  task automatic start_sync();
    @(negedge clk);
    fsync = 1'b1;
    sdata = 1'b0;
  endtask

  task automatic fill(input logic [31:0] seed, input logic [31:0] tail_ones);
    for (int s = 0; s < 8; s++) slot_w[s] = (seed * 32'(s + 3)) ^ 32'hA5C3_0F1E ^ tail_ones;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(ch_valid == 1'b0, "R1", "valid in reset", 64'(ch_valid), 64'd0);
    check(sync_err == 1'b0, "R1", "err in reset", 64'(sync_err), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ch_data == '0, "R1", "data after reset", ch_data[63:0], 64'd0);
    check(ch_valid == 1'b0, "R1", "valid after reset", 64'(ch_valid), 64'd0);
  endtask

  task automatic t_first_frame();
    word_len = 2'd3;
    fill(32'h1357_9BDF, 32'h0);
    slot_w[6] = 32'hFFFF_FFFF;
    slot_w[7] = 32'hDEAD_BEEF;
    start_sync();
    run_frame(1, 1'b1, "R2 first frame");
    check(sync_err == 1'b0, "R7", "first sync no error", 64'(sync_err), 64'd0);
  endtask

  task automatic t_back_to_back();
    fill(32'h8642_0ACE, 32'h0);
    run_frame(1, 1'b1, "R3 frame2");
    fill(32'h0F0F_F0F0, 32'h0);
    run_frame(1, 1'b1, "R3 frame3");
    check(sync_err == 1'b0, "R7", "aligned frames no error", 64'(sync_err), 64'd0);
  endtask

  task automatic t_word_lengths();
    for (int c = 0; c < 3; c++) begin
      word_len = 2'(c);
      fill(32'h2468_ACE0 + 32'(c), 32'h0000_FFFF);
      run_frame(1, 1'b1, $sformatf("R4 len code %0d", c));
    end
    word_len = 2'd3;
  endtask

  task automatic t_long_sync();
    fill(32'h7777_1234, 32'h0);
    run_frame(4, 1'b0, "R8 long fsync");
    check(sync_err == 1'b0, "R8", "long fsync no error", 64'(sync_err), 64'd0);
  endtask

  task automatic t_misaligned();
    repeat (37) begin
      @(negedge clk);
      fsync = 1'b0;
      sdata = 1'b1;
    end
    check(sync_err == 1'b0, "R7", "err before misaligned", 64'(sync_err), 64'd0);
    fill(32'hC0DE_5A5A, 32'h0);
    start_sync();
    run_frame(1, 1'b0, "R7 restart");
    check(sync_err == 1'b1, "R7", "misaligned sets error", 64'(sync_err), 64'd1);
    repeat (300) @(negedge clk);
    check(sync_err == 1'b1, "R7", "error sticky", 64'(sync_err), 64'd1);
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_back_to_back();
    t_word_lengths();
    t_long_sync();
    t_misaligned();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule